// File: doc/BRIEF.md
# Shadow RAM Store/Recall Controller

This block models a static memory of 256 four-bit words whose contents are shadowed by a backup array that stands in for nonvolatile cells. Ordinary accesses use active-low chip select and write enable with an 8-bit address. Two further active-low requests move the whole memory at once: a store copies the RAM into the backup array, and a recall copies the backup array into the RAM. The data bus is split into `data_in`, `data_out` and a drive enable `data_oe` that a pad ring turns into a tri-state bus.

All timing is synchronous. A recall lasts `RECALL_CYCLES` clocks and a store lasts `STORE_CYCLES` clocks. One word moves per clock during the first 256 clocks of either transfer, and the rest of the time is dead time. A store request is accepted only after `store_n` has been low for `STORE_MIN` consecutive clocks, so short glitches do nothing. Recall has priority over store, and both take priority over RAM accesses.

The controller is one state machine with five states:
- `ST_OFF`: the supply is not good, or reset is active.
- `ST_RECALL`: a recall is running.
- `ST_STORE`: a store is running.
- `ST_REARM`: a transfer has finished and the block waits for both requests to return high.
- `ST_IDLE`: normal access.

The transitions are:
- OFF→RECALL: the supply is good. This is the automatic recall at power-up.
- Any state→OFF: `pwr_ok` is low.
- IDLE→RECALL: `recall_n` is low.
- IDLE→STORE: the store request has been qualified and `recall_n` is high.
- RECALL→REARM and STORE→REARM: the last transfer cycle has been reached.
- REARM→IDLE: both `store_n` and `recall_n` are high.

Top module: `nvsram_ctrl`

## Requirements
- R1: In ST_IDLE, with `pwr_ok`=1, `cs_n`=0 and `we_n`=0 at a rising clock edge, `data_in` is written into the word at `addr`.
- R2: In ST_IDLE, with `pwr_ok`=1, `cs_n`=0 and `we_n`=1, `data_oe` is 1 and `data_out` shows the word at `addr` in the same cycle.
- R3: `data_oe` is 0 whenever `cs_n`=1, `busy`=1 or `pwr_ok`=0.
- R4: `recall_n`=0 in ST_IDLE starts a recall at the next edge. `busy` is then 1 for exactly RECALL_CYCLES clocks, after which the RAM equals the backup array.
- R5: `store_n` held low for STORE_MIN consecutive clocks starts a store. `busy` is then 1 for exactly STORE_CYCLES clocks, after which the backup array equals the RAM.
- R6: A `store_n` low pulse shorter than STORE_MIN clocks starts nothing. `busy` stays 0 and the backup array keeps its contents.
- R7: While a store runs, `we_n` and `recall_n` have no effect: the RAM word is not written and no recall follows. Reads are dropped.
- R8: When `store_n` and `recall_n` are both low in ST_IDLE, a recall runs and the backup array is not overwritten.
- R9: After a transfer ends, no new transfer starts until both `store_n` and `recall_n` have been high. A request held low across the end of a transfer therefore does not retrigger.
- R10: After `rst_n` is released with `pwr_ok`=1, a recall runs automatically (`busy` is 1 for RECALL_CYCLES clocks), and the RAM then equals the backup array.
- R11: `pwr_ok`=0 inhibits everything: `busy`=0, `data_oe`=0 and no store starts. When `pwr_ok` returns, an automatic recall runs.
- R12: `store_n` held low through power-up does not start a store. A store becomes possible only after `store_n` has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the control logic; the arrays keep their contents |
| pwr_ok | input | 1 | Supply-good indication; 0 inhibits all functions |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| store_n | input | 1 | Active-low store request (RAM to backup) |
| recall_n | input | 1 | Active-low recall request (backup to RAM) |
| addr | input | 8 | Word address |
| data_in | input | 4 | Write data from the bus |
| data_out | output | 4 | Read data to the bus |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |
| busy | output | 1 | High for the whole duration of a store or recall |

## Verification
Almost every state fault appears at `busy` or `data_oe` within one clock. Examples are a machine stuck in ST_REARM, a transfer entered from the wrong condition, or a wrong end count. Each one shows up as a busy window of the wrong length, a missing busy window, or a bus enabled during a transfer. A fault in the copy path, such as a wrong copy address, the wrong array written, or a dropped word, stays invisible until the next read sweep after the transfer. For that reason every store is proven indirectly: the RAM is overwritten, the backup is recalled, and all 256 words are compared against a model of both arrays.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_RECALL = 3'd2,
        ST_STORE  = 3'd3,
        ST_REARM  = 3'd4
    } nvs_state_e;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    // storage carries no reset: contents survive control-logic reset
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvs_store_filter.sv
module nvs_store_filter #(
    parameter int STORE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_n,
    output logic store_ok
);
    localparam int FW = $clog2(STORE_MIN + 1);
    localparam logic [FW-1:0] MIN_C = FW'(STORE_MIN);

    logic [FW-1:0] run_q;

    // counts consecutive low clocks, saturating at the qualification width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (store_n) begin
            run_q <= '0;
        end else if (run_q != MIN_C) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign store_ok = (run_q == MIN_C);

    // R6: qualification only follows a low request
    a_r6_ok_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        store_ok |-> $past(!store_n));

    // R6: a released request drops qualification at once
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        store_n |=> !store_ok);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
    import nvs_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 4,
    parameter int STORE_CYCLES  = 600,
    parameter int RECALL_CYCLES = 300,
    parameter int STORE_MIN     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          store_n,
    input  logic          recall_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          busy
);
    localparam int DEPTH = 1 << AW;
    localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
    localparam int CW    = $clog2(MAXC + 1) + 1;
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] ST_LAST  = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] RC_LAST  = CW'(RECALL_CYCLES - 1);

    nvs_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          store_ok;

    logic          ram_we, bak_we;
    logic [AW-1:0] ram_waddr, ram_raddr, copy_addr;
    logic [DW-1:0] ram_wdata, ram_rdata, bak_rdata;
    logic          copy_live;

    nvs_store_filter #(.STORE_MIN(STORE_MIN)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .store_n  (store_n),
        .store_ok (store_ok)
    );

    nvs_array #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    nvs_array #(.AW(AW), .DW(DW)) u_backup (
        .clk   (clk),
        .we    (bak_we),
        .waddr (copy_addr),
        .wdata (ram_rdata),
        .raddr (copy_addr),
        .rdata (bak_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!pwr_ok) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_RECALL;
                    cnt_d   = '0;
                end
                ST_IDLE: begin
                    cnt_d = '0;
                    if (!recall_n) begin
                        state_d = ST_RECALL;
                    end else if (store_ok) begin
                        state_d = ST_STORE;
                    end
                end
                ST_RECALL: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == RC_LAST) begin
                        state_d = ST_REARM;
                    end
                end
                ST_STORE: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == ST_LAST) begin
                        state_d = ST_REARM;
                    end
                end
                ST_REARM: begin
                    cnt_d = '0;
                    if (store_n && recall_n) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs and array controls
    always_comb begin
        copy_addr = cnt_q[AW-1:0];
        copy_live = (cnt_q < DEPTH_C);
        ram_we    = 1'b0;
        bak_we    = 1'b0;
        ram_waddr = addr;
        ram_wdata = data_in;
        ram_raddr = addr;
        data_oe   = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ram_we  = pwr_ok && !cs_n && !we_n;
                data_oe = pwr_ok && !cs_n && we_n;
            end
            ST_RECALL: begin
                busy      = 1'b1;
                ram_we    = copy_live;
                ram_waddr = copy_addr;
                ram_wdata = bak_rdata;
            end
            ST_STORE: begin
                busy      = 1'b1;
                bak_we    = copy_live;
                ram_raddr = copy_addr;
            end
            ST_OFF, ST_REARM: begin
            end
            default: begin
            end
        endcase
    end

    assign data_out = ram_rdata;

    // R3: the bus is never driven during a transfer
    a_r3_bus_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !data_oe);

    // R7: a store never lets a RAM write through
    a_r7_no_write_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STORE) |-> !ram_we);

    // R8: recall wins over a qualified store
    a_r8_recall_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pwr_ok && !recall_n) |=> (state_q == ST_RECALL));

    // R9: a request still held keeps the block waiting
    a_r9_hold_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && pwr_ok && (!store_n || !recall_n)) |=> (state_q == ST_REARM));

    // R11: a bad supply leaves the block quiet
    a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (state_q == ST_OFF && !bak_we));

    // R4: the transfer counter stays within the recall window
    a_r4_recall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECALL) |-> (cnt_q <= RC_LAST));
endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
    localparam int AW = 8;
    localparam int DW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int ST_CYC = 600;
    localparam int RC_CYC = 300;
    localparam int SMIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic cs_n = 1'b1, we_n = 1'b1, store_n = 1'b1, recall_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic data_oe, busy;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] bak_m [DEPTH];

    // address/data stimulus table: {addr, data}
    localparam logic [11:0] VEC [8] = '{
        12'h00_A, 12'hFF_5, 12'h80_F, 12'h7F_0,
        12'h01_3, 12'h55_C, 12'hAA_6, 12'h10_9
    };

    always #10 clk = ~clk;

    nvsram_ctrl #(.AW(AW), .DW(DW), .STORE_CYCLES(ST_CYC),
                  .RECALL_CYCLES(RC_CYC), .STORE_MIN(SMIN)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .we_n(we_n),
        .store_n(store_n), .recall_n(recall_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); data_in = DW'(d); cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        addr = AW'(a); cs_n = 1'b0; we_n = 1'b1;
        #1;
        d = data_out; oe = data_oe;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic fill(input int mul, input int add);
        for (int i = 0; i < DEPTH; i++) begin
            wr(i, (i * mul + add) & 15);
            ram_m[i] = DW'((i * mul + add) & 15);
        end
    endtask

    task automatic sweep(input string req);
        logic [DW-1:0] d;
        logic oe;
        int bad = 0;
        int first = -1;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, d, oe);
            if (d !== ram_m[i] || oe !== 1'b1) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, req, bad, 0);
    endtask

    // counts busy clocks of one window; returns 0 if none starts
    task automatic busy_len(output int n);
        int guard = 0;
        n = 0;
        while (guard < 5000) begin
            @(negedge clk);
            guard++;
            if (busy) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [DW-1:0] d;
        logic oe;

        // reset state (R3, R10)
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 reset busy", busy, 0);
        check(data_oe == 1'b0, "R3 reset bus", data_oe, 0);
        rst_n = 1'b1;
        busy_len(n);
        check(n == RC_CYC, "R10 auto recall length", n, RC_CYC);

        // R1, R2: full fill and sweep
        fill(5, 1);
        sweep("R1/R2 pattern A");

        // table walk: write then readback, plus deselected read
        for (int v = 0; v < 8; v++) begin
            wr(int'(VEC[v][11:4]), int'(VEC[v][3:0]));
            ram_m[VEC[v][11:4]] = VEC[v][3:0];
            rd(int'(VEC[v][11:4]), d, oe);
            check(d === VEC[v][3:0] && oe, "R1/R2 table", int'(d), int'(VEC[v][3:0]));
        end
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; #1;
        check(data_oe == 1'b0, "R3 deselected", data_oe, 0);

        // R5: store
        @(negedge clk); store_n = 1'b0;
        busy_len(n);
        store_n = 1'b1;
        check(n == ST_CYC, "R5 store length", n, ST_CYC);
        for (int i = 0; i < DEPTH; i++) bak_m[i] = ram_m[i];

        // R6: short pulse
        fill(3, 7);
        @(negedge clk); store_n = 1'b0;
        repeat (SMIN - 1) @(negedge clk);
        store_n = 1'b1;
        quiet(20, "R6 short pulse busy");

        // R4: recall restores backup (also proves R5 copy and R6 no store)
        @(negedge clk); recall_n = 1'b0;
        busy_len(n);
        recall_n = 1'b1;
        check(n == RC_CYC, "R4 recall length", n, RC_CYC);
        for (int i = 0; i < DEPTH; i++) ram_m[i] = bak_m[i];
        sweep("R4/R5/R6 recalled data");

        // R7: write, read, recall during store are ignored
        fill(7, 2);
        @(negedge clk); store_n = 1'b0;
        n = 0;
        while (!busy) begin @(negedge clk); end
        n = 1;
        cs_n = 1'b0; we_n = 1'b0; addr = 8'h33; data_in = ~ram_m[8'h33]; recall_n = 1'b0;
        @(negedge clk); n++;
        we_n = 1'b1; #1;
        check(data_oe == 1'b0, "R3 bus off during store", data_oe, 0);
        @(negedge clk); n++;
        cs_n = 1'b1; recall_n = 1'b1;
        begin
            int rest;
            busy_len(rest);
            n = n + rest;
        end
        store_n = 1'b1;
        check(n == ST_CYC, "R7 store not disturbed", n, ST_CYC);
        for (int i = 0; i < DEPTH; i++) bak_m[i] = ram_m[i];
        rd(8'h33, d, oe);
        check(d === ram_m[8'h33], "R7 write dropped", int'(d), int'(ram_m[8'h33]));
        quiet(10, "R7 no recall follows");

        // R8: both requests low -> recall, backup untouched
        for (int i = 0; i < 16; i++) begin
            wr(i, (i + 9) & 15);
            ram_m[i] = DW'((i + 9) & 15);
        end
        @(negedge clk); store_n = 1'b0; recall_n = 1'b0;
        busy_len(n);
        check(n == RC_CYC, "R8 recall wins", n, RC_CYC);
        // R9: still held after end -> no retrigger
        quiet(30, "R9 held requests");
        store_n = 1'b1; recall_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) ram_m[i] = bak_m[i];
        sweep("R8 backup kept");

        // R11: supply bad
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b1; addr = 8'h05; #1;
        check(data_oe == 1'b0, "R11 bus off", data_oe, 0);
        cs_n = 1'b1;
        store_n = 1'b0;
        quiet(20, "R11 no store while off");
        pwr_ok = 1'b1;
        busy_len(n);
        check(n == RC_CYC, "R11 recall on return", n, RC_CYC);
        quiet(20, "R12 held store after power return");
        store_n = 1'b1;
        sweep("R11 data after return");

        // R12: store held through reset power-up
        fill(11, 4);
        @(negedge clk); store_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        busy_len(n);
        check(n == RC_CYC, "R10 recall after reset", n, RC_CYC);
        for (int i = 0; i < DEPTH; i++) ram_m[i] = bak_m[i];
        quiet(20, "R12 no store from held request");
        store_n = 1'b1;
        sweep("R10 recalled after reset");
        fill(13, 6);
        @(negedge clk); store_n = 1'b0;
        busy_len(n);
        store_n = 1'b1;
        check(n == ST_CYC, "R12 store after re-arm", n, ST_CYC);
        for (int i = 0; i < DEPTH; i++) bak_m[i] = ram_m[i];
        fill(1, 0);
        @(negedge clk); recall_n = 1'b0;
        busy_len(n);
        recall_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) ram_m[i] = bak_m[i];
        sweep("R12 stored data");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule